// File: doc/BRIEF.md
# Serial ADC Device-Side Responder

This block plays the part of an 8-channel, 10-bit serial converter on an SPI-style link, so that a host-side master can be brought up against it in simulation or on a board. A fast system clock oversamples the active-low select, the serial clock and the serial data input. Each line goes through a two-flop synchronizer, and edges are found from the synchronized copies.

A conversion starts when select goes low. The responder skips zeros until it sees a start bit. It then takes a mode bit and a 3-bit channel number, and reports the decoded command with a one-cycle strobe. Two serial-clock falling edges later it drives a null bit. It then shifts out the 10-bit word for the chosen channel, MSB first. The words come from a parallel input bus, one slice per channel.

Two sticky flags report master misbehaviour: a read cut short by select rising early, and a violation of the select-to-clock setup or the minimum select-high time. One clear input resets both flags.

Top module: `adc_spi_responder`

## Requirements
- R1: Within 3 system-clock cycles of `cs_n` going high, `dout_oe` is low; `dout` is 0 whenever `dout_oe` is low.
- R2: After `cs_n` falls, serial-clock rising edges that sample `din`=0 are skipped; the first rising edge that samples `din`=1 is the start bit.
- R3: The rising edge after the start bit captures the mode (`cmd_single`=1 single-ended, 0 differential). The next three rising edges capture the channel, MSB first. `cmd_valid` then pulses for exactly one cycle, with `cmd_single`/`cmd_chan` holding the decoded values.
- R4: `dout_oe` stays low through the command bits. On the second serial-clock falling edge after the last channel bit, `dout_oe` goes high and `dout` carries a null bit of 0.
- R5: Each later falling edge drives the next bit of a 10-bit word, MSB first, so the master samples null then bits 9..0 on successive rising edges.
- R6: The word is `sample_flat[10*ch +: 10]` for decoded channel ch. It is latched when the null bit is driven, and later changes on `sample_flat` have no effect on the word.
- R7: If `cs_n` rises after its falling edge but before the 10th data bit has been driven, `short_read` is set. A read of all 10 bits leaves it clear.
- R8: If the first serial-clock rising edge comes fewer than TSU_CYC (20 by default) system cycles after `cs_n` falls, `timing_err` is set. Exactly TSU_CYC cycles does not set it.
- R9: If `cs_n` stays high for fewer than TCSH_CYC (54 by default) cycles between conversions, `timing_err` is set at the next fall. Exactly TCSH_CYC cycles does not set it. The first fall after reset is not checked.
- R10: `timing_err` and `short_read` stay set until `err_clr` is asserted, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversampling) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master |
| din | input | 1 | Serial command data from the master |
| sample_flat | input | CHAN_N*DATA_W | Per-channel sample words, channel 0 in the low bits |
| err_clr | input | 1 | Clears both sticky flags |
| dout | output | 1 | Serial data to the master |
| dout_oe | output | 1 | Drive enable for `dout` |
| cmd_valid | output | 1 | One-cycle strobe when the channel field completes |
| cmd_single | output | 1 | Decoded mode, 1 = single-ended |
| cmd_chan | output | CHAN_W | Decoded channel number |
| timing_err | output | 1 | Sticky setup / select-high violation |
| short_read | output | 1 | Sticky incomplete-read warning |

## Verification
The hardest cases to reach are the timing limits at their exact boundaries, and a change of the sample bus in the middle of a word. The bench drives every master line on the falling system-clock edge and counts cycles, so each select-to-clock and select-high interval is an exact cycle count. This lets it place one run at the threshold and one a single cycle below it. For the latch check, the bench rewrites the selected channel's sample right after it receives the null bit, then confirms that the old word still arrives.

// File: rtl/adc_resp_pkg.sv
`timescale 1ns/1ps
package adc_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_MODE,
    ST_CHAN,
    ST_GAP,
    ST_DATA,
    ST_DONE
  } resp_state_e;

  localparam int GAP_FALLS = 2;
endpackage

// File: rtl/adc_resp_sync.sv
`timescale 1ns/1ps
module adc_resp_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/adc_resp_timing.sv
`timescale 1ns/1ps
module adc_resp_timing #(
  parameter int TSU_CYC  = 20,
  parameter int TCSH_CYC = 54
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sclk_rise,
  input  logic err_clr,
  output logic timing_err
);
  localparam int LIM   = (TCSH_CYC > TSU_CYC) ? TCSH_CYC : TSU_CYC;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIM);

  logic [CNT_W-1:0] su_cnt_q, su_cnt_n;
  logic [CNT_W-1:0] hi_cnt_q, hi_cnt_n;
  logic             su_arm_q, su_arm_n;
  logic             hi_arm_q, hi_arm_n;
  logic             err_q, err_n;
  logic             viol;

  always_comb begin
    su_cnt_n = su_cnt_q;
    hi_cnt_n = hi_cnt_q;
    su_arm_n = su_arm_q;
    hi_arm_n = hi_arm_q;
    viol     = 1'b0;
    if (cs_fall) begin
      su_cnt_n = CNT_W'(1);
      su_arm_n = 1'b1;
      hi_arm_n = 1'b0;
      if (hi_arm_q && (hi_cnt_q < CNT_W'(TCSH_CYC))) viol = 1'b1;
    end else if (cs_rise) begin
      hi_cnt_n = CNT_W'(1);
      hi_arm_n = 1'b1;
      su_arm_n = 1'b0;
    end else begin
      if (su_arm_q && sclk_rise) begin
        su_arm_n = 1'b0;
        if (su_cnt_q < CNT_W'(TSU_CYC)) viol = 1'b1;
      end else if (su_cnt_q != CNT_MAX) begin
        su_cnt_n = su_cnt_q + CNT_W'(1);
      end
      if (hi_cnt_q != CNT_MAX) hi_cnt_n = hi_cnt_q + CNT_W'(1);
    end
    err_n = (err_q & ~err_clr) | viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt_q <= '0;
      hi_cnt_q <= '0;
      su_arm_q <= 1'b0;
      hi_arm_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      su_cnt_q <= su_cnt_n;
      hi_cnt_q <= hi_cnt_n;
      su_arm_q <= su_arm_n;
      hi_arm_q <= hi_arm_n;
      err_q    <= err_n;
    end
  end

  assign timing_err = err_q;
endmodule

// File: rtl/adc_resp_proto.sv
`timescale 1ns/1ps
module adc_resp_proto
  import adc_resp_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CHAN_N = 8,
  localparam int CHAN_W = $clog2(CHAN_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_s,
  input  logic                     cs_rise,
  input  logic                     sclk_rise,
  input  logic                     sclk_fall,
  input  logic                     din_s,
  input  logic [CHAN_N*DATA_W-1:0] sample_flat,
  input  logic                     err_clr,
  output logic                     dout,
  output logic                     dout_oe,
  output logic                     cmd_valid,
  output logic                     cmd_single,
  output logic [CHAN_W-1:0]        cmd_chan,
  output logic                     short_read
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] samp [CHAN_N];

  for (genvar g = 0; g < CHAN_N; g++) begin : g_slice
    assign samp[g] = sample_flat[g*DATA_W +: DATA_W];
  end

  resp_state_e       st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CHAN_W-1:0] chan_q, chan_n;
  logic              mode_q, mode_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;
  logic              valid_q, valid_n;
  logic              short_q, short_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    chan_n  = chan_q;
    mode_n  = mode_q;
    dout_n  = dout_q;
    oe_n    = oe_q;
    valid_n = 1'b0;
    short_n = short_q & ~err_clr;
    if (cs_s) begin
      if (cs_rise && (st_q != ST_IDLE) && (st_q != ST_DONE)) short_n = 1'b1;
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      dout_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_n = ST_HUNT;
        ST_HUNT: if (sclk_rise && din_s) st_n = ST_MODE;
        ST_MODE: if (sclk_rise) begin
          mode_n = din_s;
          cnt_n  = CNT_W'(CHAN_W - 1);
          st_n   = ST_CHAN;
        end
        ST_CHAN: if (sclk_rise) begin
          chan_n = {chan_q[CHAN_W-2:0], din_s};
          if (cnt_q == '0) begin
            valid_n = 1'b1;
            cnt_n   = CNT_W'(GAP_FALLS - 1);
            st_n    = ST_GAP;
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
          end
        end
        ST_GAP: if (sclk_fall) begin
          if (cnt_q == '0) begin
            oe_n   = 1'b1;
            dout_n = 1'b0;
            sh_n   = samp[chan_q];
            cnt_n  = CNT_W'(DATA_W);
            st_n   = ST_DATA;
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
          end
        end
        ST_DATA: if (sclk_fall) begin
          dout_n = sh_q[DATA_W-1];
          sh_n   = {sh_q[DATA_W-2:0], 1'b0};
          cnt_n  = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_n = ST_DONE;
        end
        ST_DONE: st_n = ST_DONE;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      chan_q  <= '0;
      mode_q  <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      chan_q  <= chan_n;
      mode_q  <= mode_n;
      dout_q  <= dout_n;
      oe_q    <= oe_n;
      valid_q <= valid_n;
      short_q <= short_n;
    end
  end

  assign dout       = dout_q;
  assign dout_oe    = oe_q;
  assign cmd_valid  = valid_q;
  assign cmd_single = mode_q;
  assign cmd_chan   = chan_q;
  assign short_read = short_q;
endmodule

// File: rtl/adc_spi_responder.sv
`timescale 1ns/1ps
module adc_spi_responder #(
  parameter int DATA_W   = 10,
  parameter int CHAN_N   = 8,
  parameter int CLK_NS   = 5,
  parameter int TSU_NS   = 100,
  parameter int TCSH_NS  = 270,
  localparam int CHAN_W  = $clog2(CHAN_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     din,
  input  logic [CHAN_N*DATA_W-1:0] sample_flat,
  input  logic                     err_clr,
  output logic                     dout,
  output logic                     dout_oe,
  output logic                     cmd_valid,
  output logic                     cmd_single,
  output logic [CHAN_W-1:0]        cmd_chan,
  output logic                     timing_err,
  output logic                     short_read
);
  localparam int TSU_CYC  = (TSU_NS + CLK_NS - 1) / CLK_NS;
  localparam int TCSH_CYC = (TCSH_NS + CLK_NS - 1) / CLK_NS;
  localparam int N_LINES  = 3;
  localparam logic [N_LINES-1:0] LINE_RST = 3'b001;

  logic [N_LINES-1:0] raw_lines, sync_lines;
  assign raw_lines = {din, sclk, cs_n};

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    adc_resp_sync #(.RST_VAL(LINE_RST[i])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_lines[i]),
      .q    (sync_lines[i])
    );
  end

  logic cs_s, sclk_s, din_s;
  assign cs_s   = sync_lines[0];
  assign sclk_s = sync_lines[1];
  assign din_s  = sync_lines[2];

  logic cs_prev_q, sclk_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  assign cs_rise   =  cs_s   & ~cs_prev_q;
  assign cs_fall   = ~cs_s   &  cs_prev_q;
  assign sclk_rise =  sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s &  sclk_prev_q;

  adc_resp_proto #(.DATA_W(DATA_W), .CHAN_N(CHAN_N)) u_proto (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .cs_rise    (cs_rise),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .din_s      (din_s),
    .sample_flat(sample_flat),
    .err_clr    (err_clr),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .cmd_valid  (cmd_valid),
    .cmd_single (cmd_single),
    .cmd_chan   (cmd_chan),
    .short_read (short_read)
  );

  adc_resp_timing #(.TSU_CYC(TSU_CYC), .TCSH_CYC(TCSH_CYC)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_rise (sclk_rise),
    .err_clr   (err_clr),
    .timing_err(timing_err)
  );
endmodule

// File: rtl/adc_resp_chk.sv
`timescale 1ns/1ps
module adc_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic dout,
  input logic dout_oe,
  input logic cmd_valid,
  input logic timing_err,
  input logic short_read,
  input logic err_clr
);
  a_r1_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_oe);

  a_r1_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r10_terr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_err && !err_clr) |=> timing_err);

  a_r7_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (short_read && !err_clr) |=> short_read);
endmodule

bind adc_spi_responder adc_resp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .cmd_valid (cmd_valid),
  .timing_err(timing_err),
  .short_read(short_read),
  .err_clr   (err_clr)
);

// File: tb/sim_adc_spi_responder.sv
`timescale 1ns/1ps
module sim_adc_spi_responder;
  localparam int DW = 10;
  localparam int CN = 8;
  localparam int H  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, sclk, din, err_clr;
  logic [CN*DW-1:0] sample_flat;
  logic dout, dout_oe, cmd_valid, cmd_single, timing_err, short_read;
  logic [2:0] cmd_chan;
  logic [DW-1:0] samp [CN];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < CN; i++) sample_flat[i*DW +: DW] = samp[i];
  end

  adc_spi_responder u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample_flat(sample_flat), .err_clr(err_clr), .dout(dout),
    .dout_oe(dout_oe), .cmd_valid(cmd_valid), .cmd_single(cmd_single),
    .cmd_chan(cmd_chan), .timing_err(timing_err), .short_read(short_read)
  );

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  logic       vmode;
  logic [2:0] vchan;
  logic got_d, got_oe;

  always @(negedge clk) if (cmd_valid) begin
    vcount++;
    vmode = cmd_single;
    vchan = cmd_chan;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclk_cycle(input int low, input logic d);
    din = d;
    repeat (low) @(negedge clk);
    got_d  = dout;
    got_oe = dout_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic mode, input logic [2:0] ch, input int zeros,
                      input int first_low, input int hi, input int nread,
                      input logic change_mid, input logic exp_terr, input logic exp_short);
    logic [DW-1:0] expw;
    logic [DW-1:0] word;
    int v0;
    logic [4:0] cmd;
    repeat (hi) @(negedge clk);
    v0 = vcount;
    cs_n = 1'b0;
    cmd = {1'b1, mode, ch};
    for (int z = 0; z < zeros; z++) sclk_cycle((z == 0) ? first_low : H, 1'b0);
    for (int b = 4; b >= 0; b--) sclk_cycle((zeros == 0 && b == 4) ? first_low : H, cmd[b]);
    chk("R4 oe low during command", 32'(got_oe), 32'd0);
    sclk_cycle(H, 1'b0);
    sclk_cycle(H, 1'b0);
    chk("R4 null bit enable", 32'(got_oe), 32'd1);
    chk("R4 null bit value", 32'(got_d), 32'd0);
    expw = samp[ch];
    if (change_mid) samp[ch] = ~samp[ch];
    word = '0;
    for (int k = 0; k < nread; k++) begin
      sclk_cycle(H, 1'b0);
      word = {word[DW-2:0], got_d};
    end
    if (nread == DW) chk("R5 R6 data word", 32'(word), 32'(expw));
    chk("R3 single valid pulse", 32'(vcount - v0), 32'd1);
    chk("R3 decoded mode", 32'(vmode), 32'(mode));
    chk("R3 decoded channel", 32'(vchan), 32'(ch));
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe released", 32'(dout_oe), 32'd0);
    chk("R1 dout quiet", 32'(dout), 32'd0);
    chk("R7 short_read flag", 32'(short_read), 32'(exp_short));
    chk("R8 R9 timing_err flag", 32'(timing_err), 32'(exp_terr));
  endtask

  task automatic clear_flags();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R10 timing_err cleared", 32'(timing_err), 32'd0);
    chk("R10 short_read cleared", 32'(short_read), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; err_clr = 1'b0;
    for (int i = 0; i < CN; i++) samp[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", 32'(dout_oe), 32'd0);
    chk("R1 reset dout", 32'(dout), 32'd0);
    chk("R10 reset flags", 32'({timing_err, short_read, cmd_valid}), 32'd0);

    // R2 R3 R5 R6: sweep of mode and channel, varying leading zeros
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < CN; c++) begin
        for (int i = 0; i < CN; i++)
          samp[i] = DW'((i * 131 + (m * CN + c) * 59 + 7) % 1024);
        xfer(m[0], c[2:0], (c + m) % 3, 24, 60, DW, 1'b0, 1'b0, 1'b0);
      end
    end
    samp[5] = 10'h3FF;
    xfer(1'b1, 3'd5, 0, 24, 60, DW, 1'b0, 1'b0, 1'b0);
    samp[0] = 10'h000;
    xfer(1'b0, 3'd0, 4, 24, 60, DW, 1'b0, 1'b0, 1'b0);

    // R6: change of the sample after the null bit is ignored
    samp[3] = 10'h2A5;
    xfer(1'b1, 3'd3, 1, 24, 60, DW, 1'b1, 1'b0, 1'b0);

    // R7: read cut short, then recovery after clear
    xfer(1'b1, 3'd2, 0, 24, 60, 5, 1'b0, 1'b0, 1'b1);
    xfer(1'b1, 3'd2, 0, 24, 60, DW, 1'b0, 1'b0, 1'b1);
    clear_flags();

    // R8: setup one cycle short, sticky through a clean run (R10), then exact limit
    xfer(1'b0, 3'd6, 0, 19, 60, DW, 1'b0, 1'b1, 1'b0);
    xfer(1'b0, 3'd6, 0, 24, 60, DW, 1'b0, 1'b1, 1'b0);
    clear_flags();
    xfer(1'b0, 3'd1, 0, 20, 60, DW, 1'b0, 1'b0, 1'b0);

    // R9: select-high 53 cycles (4 + 49) flags, 54 cycles does not
    xfer(1'b1, 3'd4, 0, 24, 49, DW, 1'b0, 1'b1, 1'b0);
    clear_flags();
    xfer(1'b1, 3'd7, 0, 24, 60, DW, 1'b0, 1'b0, 1'b0);
    xfer(1'b1, 3'd7, 0, 24, 50, DW, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule